// File: doc/BRIEF.md
# Fine-Grain Multithread Issue Selector

This block decides, every clock cycle, which of several hardware threads sharing one scalar pipeline may issue. Each thread presents a ready flag. It also presents a flag saying whether it is running ahead on the assumption that an earlier load hits. The selector keeps its own per-thread record of two blocking conditions: an outstanding cache miss and a long-latency operation in flight. Set and clear pulses from the pipeline and the memory system update that record.

Threads that are ready and not blocked are eligible. Eligible threads that are not speculating form the upper tier, and eligible speculating threads form the lower tier. The selector serves the upper tier whenever it is non-empty. Inside the chosen tier it picks in rotating order, starting from a pointer that moves to the thread after each winner. The result is a one-hot grant and a valid bit. Both are combinational from the current inputs and the registered state.

Top module: `fgmt_issue_sel`

## Requirements
- R1: `grant` has at most one bit set, and `grant_vld` is high exactly when one bit of `grant` is set.
- R2: `grant` never selects a thread whose `thr_ready` bit is low.
- R3: A pulse on `miss_set[i]` makes thread i ineligible from the next cycle on. A later pulse on `miss_clr[i]` makes it eligible again from the cycle after the pulse, not in the pulse cycle.
- R4: `lat_set[i]` and `lat_clr[i]` block and unblock thread i in the same way as R3, and independently of the miss condition.
- R5: If the set and clear pulses of one condition arrive in the same cycle, the set takes precedence and the thread is blocked from the next cycle.
- R6: A thread with its `spec_hit` bit high is granted only when no eligible thread has its `spec_hit` bit low.
- R7: Within a tier, the search starts at the pointer and runs upward through thread indices, wrapping from NTHR-1 to 0. After a grant to thread i the pointer becomes i+1, wrapping to 0. With all four threads eligible and not speculating, the grants run 0,1,2,3,0.
- R8: The speculating tier uses the same pointer and rotation as R7.
- R9: In a cycle with no eligible thread, `grant` is zero, `grant_vld` is low, and the pointer keeps its value.
- R10: After reset the pointer is 0 and no thread is blocked, so with every thread ready the first grant goes to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | NTHR | Thread has an instruction ready |
| spec_hit | input | NTHR | Thread is issuing past a load assumed to hit |
| miss_set | input | NTHR | Cache miss starts for the thread |
| miss_clr | input | NTHR | Cache miss resolved for the thread |
| lat_set | input | NTHR | Long-latency operation starts for the thread |
| lat_clr | input | NTHR | Long-latency operation completed for the thread |
| grant | output | NTHR | One-hot issue grant |
| grant_vld | output | 1 | A thread is granted this cycle |

## Verification
The bench targets the timing of the blocking conditions. A design that applies a clear in the same cycle would grant too early in the pulse cycle. A design that lets the clear win a same-cycle collision would grant a thread that should stay blocked.

It checks that the pointer holds through cycles with no eligible thread. A pointer that drifted there would resume from the wrong thread.

It mixes speculating and non-speculating threads. A flat round-robin would hand the slot to a speculating thread while a non-speculating thread was waiting. Sparse ready patterns expose a rotation that steps one index per cycle instead of jumping to the thread after the winner.

// File: rtl/fgmt_issue_sel.sv
module fgmt_issue_sel #(
  parameter int NTHR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] spec_hit,
  input  logic [NTHR-1:0] miss_set,
  input  logic [NTHR-1:0] miss_clr,
  input  logic [NTHR-1:0] lat_set,
  input  logic [NTHR-1:0] lat_clr,
  output logic [NTHR-1:0] grant,
  output logic            grant_vld
);
  localparam int PW = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [NTHR-1:0] miss_q, lat_q, elig, tier;
  logic [PW-1:0]   ptr, sel_idx, nxt_ptr;

  assign elig = thr_ready & ~miss_q & ~lat_q;
  assign tier = (|(elig & ~spec_hit)) ? (elig & ~spec_hit) : (elig & spec_hit);

  always_comb begin
    grant     = '0;
    grant_vld = 1'b0;
    sel_idx   = '0;
    for (int k = 0; k < NTHR; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NTHR) j = j - NTHR;
      if (!grant_vld && tier[j]) begin
        grant_vld = 1'b1;
        grant[j]  = 1'b1;
        sel_idx   = PW'(j);
      end
    end
  end

  assign nxt_ptr = (sel_idx == PW'(NTHR - 1)) ? '0 : sel_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      miss_q <= '0;
      lat_q  <= '0;
    end else begin
      if (grant_vld) ptr <= nxt_ptr;
      miss_q <= miss_set | (miss_q & ~miss_clr);
      lat_q  <= lat_set | (lat_q & ~lat_clr);
    end
  end
endmodule

// File: rtl/fgmt_issue_sel_chk.sv
module fgmt_issue_sel_chk #(
  parameter int NTHR = 4,
  parameter int PW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] thr_ready,
  input logic [NTHR-1:0] spec_hit,
  input logic [NTHR-1:0] miss_set,
  input logic [NTHR-1:0] lat_set,
  input logic [NTHR-1:0] miss_q,
  input logic [NTHR-1:0] lat_q,
  input logic [PW-1:0]   ptr,
  input logic [NTHR-1:0] grant,
  input logic            grant_vld
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r1_valid: assert property (@(posedge clk) disable iff (!rst_n) grant_vld == (|grant));
  a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~thr_ready) == '0);
  a_r3_miss_block: assert property (@(posedge clk) disable iff (!rst_n) (grant & miss_q) == '0);
  a_r4_lat_block: assert property (@(posedge clk) disable iff (!rst_n) (grant & lat_q) == '0);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(miss_set | lat_set)) |=> (((miss_q & $past(miss_set)) == $past(miss_set)) &&
                                 ((lat_q & $past(lat_set)) == $past(lat_set))));
  a_r6_tier: assert property (@(posedge clk) disable iff (!rst_n)
    (|(thr_ready & ~miss_q & ~lat_q & ~spec_hit)) |-> ((grant & spec_hit) == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n) !grant_vld |=> $stable(ptr));
endmodule

bind fgmt_issue_sel fgmt_issue_sel_chk #(.NTHR(NTHR), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .spec_hit(spec_hit),
  .miss_set(miss_set), .lat_set(lat_set), .miss_q(miss_q), .lat_q(lat_q),
  .ptr(ptr), .grant(grant), .grant_vld(grant_vld)
);

// File: tb/fgmt_issue_sel_test.sv
module fgmt_issue_sel_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] thr_ready = 0, spec_hit = 0, miss_set = 0, miss_clr = 0, lat_set = 0, lat_clr = 0;
  logic [N-1:0] grant;
  logic grant_vld;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  fgmt_issue_sel #(.NTHR(N)) uut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .spec_hit(spec_hit),
    .miss_set(miss_set), .miss_clr(miss_clr), .lat_set(lat_set), .lat_clr(lat_clr),
    .grant(grant), .grant_vld(grant_vld)
  );

  task automatic chk(input string req, input logic [N-1:0] eg);
    logic ev;
    ev = |eg;
    #1;
    checks++;
    if (grant !== eg || grant_vld !== ev) begin
      fails++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b", req, grant, grant_vld, eg, ev);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
    miss_set = 0; miss_clr = 0; lat_set = 0; lat_clr = 0;
  endtask

  task automatic do_reset;
    rst_n = 0; thr_ready = 0; spec_hit = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R10 idle", 4'b0000);
    thr_ready = 4'b1111;
    chk("R10 first", 4'b0001);
  endtask

  task automatic t_rotate;
    do_reset();
    thr_ready = 4'b1111;
    chk("R7 g0", 4'b0001); step();
    chk("R7 g1", 4'b0010); step();
    chk("R7 g2", 4'b0100); step();
    chk("R7 g3", 4'b1000); step();
    chk("R7 wrap", 4'b0001);
    do_reset();
    thr_ready = 4'b0101;
    chk("R7 R2 sparse a", 4'b0001); step();
    chk("R7 R2 sparse b", 4'b0100); step();
    chk("R7 R2 sparse c", 4'b0001);
  endtask

  task automatic t_hold;
    do_reset();
    thr_ready = 4'b1111;
    chk("R9 pre", 4'b0001); step();
    thr_ready = 4'b0000;
    chk("R9 none", 4'b0000); step();
    chk("R9 none2", 4'b0000); step();
    thr_ready = 4'b1111;
    chk("R9 resume", 4'b0010);
  endtask

  task automatic t_tiers;
    do_reset();
    thr_ready = 4'b1111; spec_hit = 4'b0011;
    chk("R6 hi a", 4'b0100); step();
    chk("R6 hi b", 4'b1000); step();
    chk("R6 hi c", 4'b0100); step();
    thr_ready = 4'b0011;
    chk("R8 spec a", 4'b0001); step();
    chk("R8 spec b", 4'b0010); step();
    chk("R8 spec c", 4'b0001);
  endtask

  task automatic t_miss;
    do_reset();
    thr_ready = 4'b0001;
    miss_set = 4'b0001;
    chk("R3 set cycle", 4'b0001); step();
    chk("R3 blocked", 4'b0000); step();
    miss_clr = 4'b0001;
    chk("R3 clr cycle", 4'b0000); step();
    chk("R3 released", 4'b0001);
  endtask

  task automatic t_lat;
    do_reset();
    thr_ready = 4'b0010;
    lat_set = 4'b0010;
    chk("R4 set cycle", 4'b0010); step();
    miss_set = 4'b0010;
    chk("R4 blocked", 4'b0000); step();
    lat_clr = 4'b0010;
    chk("R4 clr cycle", 4'b0000); step();
    chk("R4 miss still", 4'b0000);
    miss_clr = 4'b0010; step();
    chk("R4 released", 4'b0010);
  endtask

  task automatic t_collide;
    do_reset();
    thr_ready = 4'b0001;
    miss_set = 4'b0001; miss_clr = 4'b0001;
    chk("R5 pulse cycle", 4'b0001); step();
    chk("R5 set wins", 4'b0000); step();
    chk("R5 still", 4'b0000);
    miss_clr = 4'b0001; step();
    chk("R5 released", 4'b0001);
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_rotate();
    t_hold();
    t_tiers();
    t_miss();
    t_lat();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule